// File: doc/BRIEF.md
# Chainable Dot-Matrix Serial Front End

This block receives the serial stream for one dot-matrix display driver and is built so that many drivers can share one set of bus lines. Data arrives one bit per rising `clk` edge on `din` while the load-enable `ce` is low. The level of `rs` when the load starts picks the target: a long pixel shift register, or an 8-bit command shift register. When `ce` returns high, the shifted contents are copied into the matching latched register. The 8-bit command byte carries its own selector bit, which routes the byte to one of two words. One is a 7-bit brightness word. The other holds two mode flags.

The `dout` output feeds the `din` of the next chip in the chain. During pixel loads, and during command loads in the normal mode, `dout` is the last stage of the active shift register, so bits ripple from chip to chip. A mode flag can turn `dout` into a direct copy of `din` for command loads only. With that flag set, a whole chain of chips takes the same command byte in 8 clocks rather than 8 clocks per chip.

The block also times the display refresh. It takes a display oscillator tick, either from this chip's own oscillator or from another chip's, and can divide an external tick by 8. It counts 512 display ticks per frame and emits a one-cycle frame pulse on each wrap. The tick it has chosen is passed on to `osc_out`, so other chips can run from it.

The load sequencer has three states. `S_IDLE` is the state while `ce` is high. `S_DOT` and `S_CTRL` are the pixel and command loads. Its transitions are:
- LOAD_DOT, from `S_IDLE` to `S_DOT`: `ce` is seen low while `rs` is low.
- LOAD_CTRL, from `S_IDLE` to `S_CTRL`: `ce` is seen low while `rs` is high.
- COMMIT_DOT, from `S_DOT` to `S_IDLE`: `ce` is seen high, and the pixel latch is written.
- COMMIT_CTRL, from `S_CTRL` to `S_IDLE`: `ce` is seen high, and the command word is written.

Top module: `dotmatrix_serial_if`

## Requirements
- R1: While `rst_n` is low, `dot_data`, `bright_word`, `dout_simul`, `osc_prescale` and `frame_pulse` are all cleared. So after reset `dout` is in chained mode and the divider is off.
- R2: On every rising `clk` with `ce` low and the pixel target selected, `din` enters stage 0 of the 160-stage pixel shift register and every other stage moves up by one. The target is chosen by `rs` on the first edge that sees `ce` low. On the first edge that sees `ce` high again, the register is copied to `dot_data`. The first bit sent therefore lands in `dot_data[159]`.
- R3: `dot_data`, `bright_word`, `dout_simul` and `osc_prescale` do not change on any edge where `ce` is low.
- R4: While the pixel target is selected, `dout` equals stage 159 of the pixel shift register, whatever the value of `dout_simul`.
- R5: While the command target is selected and `dout_simul` is 0, `dout` equals stage 7 of the command shift register. The first bit sent reaches `dout` after exactly 8 clocks.
- R6: While the command target is selected and `dout_simul` is 1, `dout` equals `din` with no clock delay.
- R7: Command bytes are sent MSB first, and the committed byte's bit 7 picks the word. With bit 7 at 0, bits 6..0 go to `bright_word`. With bit 7 at 1, bit 0 goes to `dout_simul` and bit 1 goes to `osc_prescale`, and bits 6..2 are dropped. A write to one word leaves the other word unchanged.
- R8: `frame_pulse` is high for exactly one cycle, on the cycle after every 512th display tick.
- R9: With `is_master` low, `osc_ext` is the tick source. With `osc_prescale` also set, only every 8th `osc_ext` tick counts as a display tick, so a frame takes 4096 `osc_ext` ticks.
- R10: With `is_master` high, `osc_local` is the tick source and `osc_prescale` has no effect, so a frame takes 512 `osc_local` ticks.
- R11: `osc_out` equals `osc_local` when `is_master` is high, and equals `osc_ext` otherwise.
- R12: `drive_en` is the inverse of `blank`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial shift clock, also samples the oscillator ticks |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 1 | Serial data in |
| ce | input | 1 | Load enable, active low; its rise commits the load |
| rs | input | 1 | Target select at load start: 0 = pixels, 1 = command |
| blank | input | 1 | Blanks the LED drive |
| is_master | input | 1 | 1 = use the local oscillator, 0 = use the external tick |
| osc_local | input | 1 | Local oscillator tick, one cycle per tick |
| osc_ext | input | 1 | External oscillator tick, one cycle per tick |
| dout | output | 1 | Serial data out to the next chip |
| osc_out | output | 1 | Selected oscillator tick, passed on to other chips |
| frame_pulse | output | 1 | One-cycle pulse at each refresh wrap |
| drive_en | output | 1 | LED drive enable |
| dot_data | output | 160 | Latched pixel bits |
| bright_word | output | 7 | Latched word 0 |
| dout_simul | output | 1 | Word 1 bit 0: `dout` copies `din` during command loads |
| osc_prescale | output | 1 | Word 1 bit 1: divide the external tick by 8 |

## Verification
The hardest case to reach is the broadcast `dout` path while a pixel load is in progress. The chip must be put in broadcast mode by a command write first. A pixel load must then be opened on a shift register whose contents are already known. Only then can the bench show that `dout` follows the pixel chain and ignores `din`. The stimulus gets there by walking a table of command bytes that ends in broadcast mode, after a pixel pattern has been loaded. It then drives `din` opposite to the expected chain bit on each shift. The 4096-tick divided frame is also deep: it is reached only after a command write has set the divider and the tick source has been switched to the external input.

// File: rtl/dsi_pkg.sv
package dsi_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_DOT,
        S_CTRL
    } load_state_t;

    localparam int CMD_BITS  = 8;
    localparam int WORD_SEL  = 7;
    localparam int FLAG_SIM  = 0;
    localparam int FLAG_PRE  = 1;
    localparam int BRIGHT_W  = 7;
endpackage

// File: rtl/dsi_loader.sv
module dsi_loader
    import dsi_pkg::*;
#(
    parameter int DOTS = 160
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                din,
    input  logic                ce,
    input  logic                rs,
    output logic                ctrl_sel,
    output logic                dot_tail,
    output logic                ctrl_tail,
    output logic [DOTS-1:0]     dot_data,
    output logic [BRIGHT_W-1:0] bright_word,
    output logic                dout_simul,
    output logic                osc_prescale
);
    load_state_t state_q, state_d;
    logic [DOTS-1:0]     dot_sr;
    logic [CMD_BITS-1:0] cmd_sr;
    logic shift_dot, shift_cmd, commit_dot, commit_cmd;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (!ce) state_d = rs ? S_CTRL : S_DOT;
            S_DOT:   if (ce)  state_d = S_IDLE;
            S_CTRL:  if (ce)  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    assign ctrl_sel   = (state_q == S_CTRL) || ((state_q == S_IDLE) && !ce && rs);
    assign shift_dot  = !ce && !ctrl_sel;
    assign shift_cmd  = !ce && ctrl_sel;
    assign commit_dot = ce && (state_q == S_DOT);
    assign commit_cmd = ce && (state_q == S_CTRL);
    assign dot_tail   = dot_sr[DOTS-1];
    assign ctrl_tail  = cmd_sr[CMD_BITS-1];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // shift chains
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dot_sr <= '0;
            cmd_sr <= '0;
        end else begin
            if (shift_dot) dot_sr <= {dot_sr[DOTS-2:0], din};
            if (shift_cmd) cmd_sr <= {cmd_sr[CMD_BITS-2:0], din};
        end
    end

    // latched outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dot_data     <= '0;
            bright_word  <= '0;
            dout_simul   <= 1'b0;
            osc_prescale <= 1'b0;
        end else begin
            if (commit_dot) dot_data <= dot_sr;
            if (commit_cmd) begin
                if (cmd_sr[WORD_SEL]) begin
                    dout_simul   <= cmd_sr[FLAG_SIM];
                    osc_prescale <= cmd_sr[FLAG_PRE];
                end else begin
                    bright_word  <= cmd_sr[BRIGHT_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/dsi_dout_mux.sv
module dsi_dout_mux (
    input  logic ctrl_sel,
    input  logic simul,
    input  logic din,
    input  logic dot_tail,
    input  logic ctrl_tail,
    output logic dout
);
    always_comb begin
        if (ctrl_sel) dout = simul ? din : ctrl_tail;
        else          dout = dot_tail;
    end
endmodule

// File: rtl/dsi_refresh.sv
module dsi_refresh #(
    parameter int FRAME_TICKS = 512,
    parameter int PRESCALE    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic is_master,
    input  logic osc_local,
    input  logic osc_ext,
    input  logic prescale,
    output logic osc_out,
    output logic frame_pulse
);
    localparam int FRAME_W = $clog2(FRAME_TICKS);
    localparam logic [FRAME_W-1:0] FRAME_LAST = FRAME_W'(FRAME_TICKS - 1);

    logic sel_tick, disp_tick;
    logic [FRAME_W-1:0] frame_q;

    assign sel_tick = is_master ? osc_local : osc_ext;
    assign osc_out  = sel_tick;

    generate
        if (PRESCALE > 1) begin : g_div
            localparam int PRE_W = $clog2(PRESCALE);
            localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
            logic [PRE_W-1:0] pre_q;
            logic use_div;
            assign use_div   = !is_master && prescale;
            assign disp_tick = sel_tick && (!use_div || (pre_q == PRE_LAST));
            always_ff @(posedge clk) begin
                if (!rst_n)                   pre_q <= '0;
                else if (use_div && sel_tick) pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
            end
        end else begin : g_nodiv
            logic unused_pre;
            assign unused_pre = prescale;
            assign disp_tick  = sel_tick;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q     <= '0;
            frame_pulse <= 1'b0;
        end else begin
            frame_pulse <= disp_tick && (frame_q == FRAME_LAST);
            if (disp_tick) frame_q <= (frame_q == FRAME_LAST) ? '0 : frame_q + 1'b1;
        end
    end
endmodule

// File: rtl/dotmatrix_serial_if.sv
module dotmatrix_serial_if
    import dsi_pkg::*;
#(
    parameter int DOTS        = 160,
    parameter int FRAME_TICKS = 512,
    parameter int PRESCALE    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                din,
    input  logic                ce,
    input  logic                rs,
    input  logic                blank,
    input  logic                is_master,
    input  logic                osc_local,
    input  logic                osc_ext,
    output logic                dout,
    output logic                osc_out,
    output logic                frame_pulse,
    output logic                drive_en,
    output logic [DOTS-1:0]     dot_data,
    output logic [BRIGHT_W-1:0] bright_word,
    output logic                dout_simul,
    output logic                osc_prescale
);
    logic ctrl_sel, dot_tail, ctrl_tail;

    dsi_loader #(.DOTS(DOTS)) u_loader (
        .clk(clk), .rst_n(rst_n), .din(din), .ce(ce), .rs(rs),
        .ctrl_sel(ctrl_sel), .dot_tail(dot_tail), .ctrl_tail(ctrl_tail),
        .dot_data(dot_data), .bright_word(bright_word),
        .dout_simul(dout_simul), .osc_prescale(osc_prescale)
    );

    dsi_dout_mux u_mux (
        .ctrl_sel(ctrl_sel), .simul(dout_simul), .din(din),
        .dot_tail(dot_tail), .ctrl_tail(ctrl_tail), .dout(dout)
    );

    dsi_refresh #(.FRAME_TICKS(FRAME_TICKS), .PRESCALE(PRESCALE)) u_refresh (
        .clk(clk), .rst_n(rst_n), .is_master(is_master),
        .osc_local(osc_local), .osc_ext(osc_ext), .prescale(osc_prescale),
        .osc_out(osc_out), .frame_pulse(frame_pulse)
    );

    assign drive_en = !blank;
endmodule

// File: rtl/dsi_checker.sv
module dsi_checker #(
    parameter int DOTS = 160
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ce,
    input logic            din,
    input logic            dout,
    input logic            ctrl_sel,
    input logic            dout_simul,
    input logic            osc_prescale,
    input logic [6:0]      bright_word,
    input logic [DOTS-1:0] dot_data,
    input logic            frame_pulse
);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!dout_simul && !osc_prescale && bright_word == '0 && !frame_pulse));

    a_r3_hold_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> ($stable(dot_data) && $stable(bright_word) && $stable(dout_simul) && $stable(osc_prescale)));

    a_r6_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_sel && dout_simul) |-> (dout == din));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> !frame_pulse);
endmodule

bind dotmatrix_serial_if dsi_checker #(.DOTS(DOTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce(ce), .din(din), .dout(dout),
    .ctrl_sel(ctrl_sel), .dout_simul(dout_simul), .osc_prescale(osc_prescale),
    .bright_word(bright_word), .dot_data(dot_data), .frame_pulse(frame_pulse)
);

// File: tb/test_dotmatrix_serial_if.sv
module test_dotmatrix_serial_if;
    localparam int DOTS = 160;
    localparam int NV   = 7;
    // {byte, expected bright_word, expected dout_simul, expected osc_prescale}
    localparam logic [16:0] VEC [NV] = '{
        {8'h2A, 7'h2A, 1'b0, 1'b0},
        {8'h83, 7'h2A, 1'b1, 1'b1},
        {8'h7F, 7'h7F, 1'b1, 1'b1},
        {8'hFC, 7'h7F, 1'b0, 1'b0},
        {8'h82, 7'h7F, 1'b0, 1'b1},
        {8'h00, 7'h00, 1'b0, 1'b1},
        {8'h81, 7'h00, 1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n, din, ce, rs, blank, is_master, osc_local, osc_ext;
    logic dout, osc_out, frame_pulse, drive_en, dout_simul, osc_prescale;
    logic [DOTS-1:0] dot_data;
    logic [6:0] bright_word;
    int checks = 0;
    int errors = 0;
    int mism;

    always #2 clk = ~clk;

    dotmatrix_serial_if i_dotmatrix_serial_if (
        .clk(clk), .rst_n(rst_n), .din(din), .ce(ce), .rs(rs), .blank(blank),
        .is_master(is_master), .osc_local(osc_local), .osc_ext(osc_ext),
        .dout(dout), .osc_out(osc_out), .frame_pulse(frame_pulse),
        .drive_en(drive_en), .dot_data(dot_data), .bright_word(bright_word),
        .dout_simul(dout_simul), .osc_prescale(osc_prescale)
    );

    function automatic logic pat(input int j);
        return ((j % 3) == 0) ^ (j == 5);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic shift_bit(input logic b);
        din = b;
        ce  = 1'b0;
        tick();
    endtask

    task automatic send_cmd(input logic [7:0] b);
        rs = 1'b1;
        for (int k = 7; k >= 0; k--) shift_bit(b[k]);
        ce = 1'b1;
        tick();
    endtask

    task automatic run_frame(input string tag, input int expect_n);
        int n;
        n = -1;
        for (int i = 1; i <= 5000; i++) begin
            tick();
            if (frame_pulse) begin
                n = i;
                break;
            end
        end
        chk(tag, n, expect_n);
        osc_local = 1'b0;
        osc_ext   = 1'b0;
        tick();
        chk({tag, " pulse one cycle (R8)"}, frame_pulse, 0);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; din = 0; ce = 1; rs = 0; blank = 0;
        is_master = 1; osc_local = 0; osc_ext = 0;
        repeat (3) tick();
        // R1 reset state
        chk("R1 dot_data", (dot_data == '0), 1);
        chk("R1 bright_word", bright_word, 0);
        chk("R1 dout_simul", dout_simul, 0);
        chk("R1 osc_prescale", osc_prescale, 0);
        chk("R1 frame_pulse", frame_pulse, 0);
        rst_n = 1;
        tick();

        // R12 blank
        blank = 1; #1;
        chk("R12 blanked", drive_en, 0);
        blank = 0; #1;
        chk("R12 driving", drive_en, 1);

        // R5 serial command chain: first bit appears after 8 clocks
        rs = 1;
        shift_bit(1'b1);
        for (int k = 0; k < 6; k++) shift_bit(1'b0);
        chk("R5 dout after 7 shifts", dout, 0);
        shift_bit(1'b0);
        chk("R5 dout after 8 shifts", dout, 1);
        ce = 1;
        tick();
        chk("R7 word1 zero flags", {dout_simul, osc_prescale}, 0);

        // R2/R3/R4 pixel load
        rs = 0;
        for (int j = 0; j < DOTS; j++) shift_bit(pat(j));
        chk("R3 dot_data held while ce low", (dot_data == '0), 1);
        chk("R4 dout is pixel tail", dout, pat(0));
        ce = 1;
        tick();
        mism = 0;
        for (int j = 0; j < DOTS; j++) if (dot_data[DOTS-1-j] !== pat(j)) mism++;
        chk("R2 pixel order mismatches", mism, 0);

        // R7 command table
        for (int v = 0; v < NV; v++) begin
            send_cmd(VEC[v][16:9]);
            chk("R7 bright_word", bright_word, VEC[v][8:2]);
            chk("R7 dout_simul", dout_simul, VEC[v][1]);
            chk("R7 osc_prescale", osc_prescale, VEC[v][0]);
        end

        // R6 broadcast during command load (mode is on after the table)
        rs = 1; ce = 0;
        din = 1; #1;
        chk("R6 dout follows din high", dout, 1);
        din = 0; #1;
        chk("R6 dout follows din low", dout, 0);
        for (int k = 7; k >= 0; k--) begin
            din = ~k[0]; #1;
            chk("R6 dout copies din", dout, din);
            tick();
        end
        ce = 1;
        tick();
        chk("R7 broadcast word kept", dout_simul, 1);

        // R4 pixel load ignores broadcast mode
        rs = 0; ce = 0;
        din = ~pat(0); #1;
        chk("R4 tail not din", dout, pat(0));
        tick();
        din = ~pat(1); #1;
        chk("R4 tail after shift", dout, pat(1));
        tick();
        ce = 1;
        tick();

        // R10 master ignores divider
        send_cmd(8'h82);
        chk("R7 prescale set", osc_prescale, 1);
        is_master = 1; osc_local = 1; #1;
        chk("R11 master route", osc_out, 1);
        run_frame("R10 master frame ticks", 512);

        // R9 slave with divider
        is_master = 0; osc_ext = 1; #1;
        chk("R11 slave route", osc_out, 1);
        run_frame("R9 divided frame ticks", 4096);

        // R8 slave without divider
        send_cmd(8'h80);
        chk("R7 prescale cleared", osc_prescale, 0);
        osc_ext = 1;
        run_frame("R8 undivided frame ticks", 512);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule